// File: doc/BRIEF.md
# Power-Good Monitor with Open-Phase Detection

This block produces the power-good indication of a multiphase buck regulator. Two conditions are combined. The first is a digital flag from external window comparators that reports whether the output voltage is inside its allowed band. The second confirms that each active phase is actually carrying current. The oscillator marks the end of every switching cycle with a one-clock tick. At that tick the block receives the index of the phase that just ran and a flag that reports whether current was seen in it.

A separate saturating miss counter is kept for each phase. A phase that goes three of its own cycles in a row without current is taken to have an open power path, and power-good drops even though the voltage is in range. A select input chooses whether two or three phases run. Only the running phases are watched. Changing the select discards all miss history.

The output is an open-drain enable. A high level releases the line to the external pull-up, which signals good power. A low level pulls the line down.

Top module: `pg_monitor`

## Requirements
- R1: When `inWindow` is low at a rising clock edge, `pgoodRelease` is low after that edge, whatever the miss counters hold.
- R2: When `inWindow` is high at an edge and no active phase is faulted, `pgoodRelease` is high after that edge. The output is registered, so it reflects inputs with one clock of latency. A value of 1 means release to pull-up and 0 means pull low.
- R3: A tick with `currentSeen` low increments the counter of phase `phaseIdx`. The counter's third consecutive miss makes that phase faulted, and `pgoodRelease` goes low after the following edge.
- R4: A tick with `currentSeen` high clears that phase's counter. A faulted phase recovers with one such tick, and power-good returns after the following edge when the voltage is in window.
- R5: A tick touches only the counter of the indexed phase. Misses on one phase still accumulate while other phases show current in between.
- R6: `threePhase`=0 selects two phases (indices 0 and 1) and `threePhase`=1 selects three phases (indices 0, 1 and 2). Ticks naming an unselected phase are ignored, and misses on such a phase never lower power-good.
- R7: Any change of `threePhase` clears every miss counter in that cycle, and a tick in that same cycle is ignored.
- R8: Reset clears all counters and the registered select, and holds `pgoodRelease` low until the first edge after reset with `inWindow` high.
- R9: The miss counters saturate at the limit. Further missed ticks keep the phase faulted, and one tick with current still clears it.
- R10: Clock cycles without `oscTick` leave every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWindow | input | 1 | Output voltage inside its window (from external comparators) |
| oscTick | input | 1 | One-clock pulse at the end of each switching cycle |
| phaseIdx | input | PG_IDXW (2) | Phase that ran in the cycle ending at this tick |
| currentSeen | input | 1 | Current was detected during that phase's on time |
| threePhase | input | 1 | 0 = two phases, 1 = three phases |
| pgoodRelease | output | 1 | 1 = release to pull-up (power good), 0 = pull low |

## Verification
The bench builds the block with its defaults: three phase slots and a miss limit of three. This places both selectable phase counts and the exact third-miss boundary within reach. With these values a short stimulus can show that a fault does not appear after two misses, that it does appear after the third, and that extra misses only hold the saturated count. Phase index 2 serves as an unselected slot in two-phase mode. The bench therefore tests both the ignoring of that slot and the clearing of counters when the select changes.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;
  // Number of phase slots the monitor can track
  parameter int unsigned PG_PHASES = 3;
  // Width of the phase index input
  parameter int unsigned PG_IDXW = (PG_PHASES > 1) ? $clog2(PG_PHASES) : 1;

  // Strobes from the control to the miss-counter bank
  typedef struct packed {
    logic                 clearAll; // drop every counter (select changed)
    logic [PG_PHASES-1:0] bump;     // count one missed cycle
    logic [PG_PHASES-1:0] wipe;     // current seen: clear counter
  } pgStrobe_t;
endpackage

// File: rtl/pg_miss_bank.sv
module pg_miss_bank
  import pg_mon_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pgStrobe_t            strobe,
  output logic [PG_PHASES-1:0] phaseFault
);
  localparam int unsigned CNTW = $clog2(MISS_LIMIT + 1);
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(MISS_LIMIT);

  // A tick addresses a single phase only
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.bump | strobe.wipe)); // R5

  for (genvar p = 0; p < PG_PHASES; p++) begin : gPhase
    logic [CNTW-1:0] missCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        missCnt <= '0;
      end else if (strobe.clearAll) begin
        missCnt <= '0;
      end else if (strobe.wipe[p]) begin
        missCnt <= '0;
      end else if (strobe.bump[p] && (missCnt != CNT_MAX)) begin
        missCnt <= missCnt + CNTW'(1);
      end
    end

    assign phaseFault[p] = (missCnt == CNT_MAX);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      missCnt <= CNT_MAX); // R9
    AST_SEEN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wipe[p] |=> (missCnt == '0)); // R4
    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clearAll |=> (missCnt == '0)); // R7
  end
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inWindow,
  input  logic                 oscTick,
  input  logic [PG_IDXW-1:0]   phaseIdx,
  input  logic                 currentSeen,
  input  logic                 threePhase,
  input  logic [PG_PHASES-1:0] phaseFault,
  output pgStrobe_t            strobe,
  output logic                 pgoodRelease
);
  localparam int unsigned N_HI = PG_PHASES;
  localparam int unsigned N_LO = PG_PHASES - 1;

  logic                 selQ;
  logic                 selChange;
  logic [PG_PHASES-1:0] activeMask;
  logic                 openPhase;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= threePhase;
  end

  assign selChange = (threePhase != selQ);

  for (genvar p = 0; p < PG_PHASES; p++) begin : gMask
    assign activeMask[p] = selQ ? (p < N_HI) : (p < N_LO);
  end

  always_comb begin
    strobe          = '0;
    strobe.clearAll = selChange;
    if (!selChange && oscTick) begin
      for (int p = 0; p < PG_PHASES; p++) begin
        if ((phaseIdx == PG_IDXW'(p)) && activeMask[p]) begin
          if (currentSeen) strobe.wipe[p] = 1'b1;
          else             strobe.bump[p] = 1'b1;
        end
      end
    end
  end

  assign openPhase = |(phaseFault & activeMask);

  always_ff @(posedge clk) begin
    if (!rstN) pgoodRelease <= 1'b0;
    else       pgoodRelease <= inWindow && !openPhase;
  end

  AST_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !inWindow |=> !pgoodRelease); // R1
  AST_OPEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    openPhase |=> !pgoodRelease); // R3
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor
  import pg_mon_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inWindow,
  input  logic               oscTick,
  input  logic [PG_IDXW-1:0] phaseIdx,
  input  logic               currentSeen,
  input  logic               threePhase,
  output logic               pgoodRelease
);
  pgStrobe_t            strobe;
  logic [PG_PHASES-1:0] phaseFault;

  pg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inWindow     (inWindow),
    .oscTick      (oscTick),
    .phaseIdx     (phaseIdx),
    .currentSeen  (currentSeen),
    .threePhase   (threePhase),
    .phaseFault   (phaseFault),
    .strobe       (strobe),
    .pgoodRelease (pgoodRelease)
  );

  pg_miss_bank #(.MISS_LIMIT(MISS_LIMIT)) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phaseFault (phaseFault)
  );
endmodule

// File: tb/sim_pg_monitor.sv
module sim_pg_monitor;
  import pg_mon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inWindow = 1'b0;
  logic oscTick = 1'b0;
  logic [PG_IDXW-1:0] phaseIdx = '0;
  logic currentSeen = 1'b0;
  logic threePhase = 1'b0;
  logic pgoodRelease;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_monitor u0 (
    .clk(clk), .rstN(rstN), .inWindow(inWindow), .oscTick(oscTick),
    .phaseIdx(phaseIdx), .currentSeen(currentSeen), .threePhase(threePhase),
    .pgoodRelease(pgoodRelease)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t sbq[$];
  int applied = 0;
  int bad = 0;
  int cntM[PG_PHASES];
  logic selM = 1'b0;
  logic curSel = 1'b1;

  // Driver: apply one cycle of inputs and predict the output after the next edge
  task automatic step(input logic win, input logic tk, input int idx,
                      input logic seen, input logic sel, input string tag);
    int nAct;
    logic flt;
    @(negedge clk);
    inWindow = win; oscTick = tk; phaseIdx = PG_IDXW'(idx);
    currentSeen = seen; threePhase = sel;
    nAct = selM ? PG_PHASES : PG_PHASES - 1;
    flt = 1'b0;
    for (int p = 0; p < nAct; p++) if (cntM[p] >= LIMIT) flt = 1'b1;
    sbq.push_back('{win && !flt, tag});
    if (sel != selM) begin
      for (int p = 0; p < PG_PHASES; p++) cntM[p] = 0;
      selM = sel;
    end else if (tk && idx < nAct) begin
      if (seen) cntM[idx] = 0;
      else if (cntM[idx] < LIMIT) cntM[idx] = cntM[idx] + 1;
    end
  endtask

  task automatic tickp(input int idx, input logic seen, input string tag);
    step(1'b1, 1'b1, idx, seen, curSel, tag);
  endtask

  task automatic idle(input logic win, input int n, input string tag);
    for (int i = 0; i < n; i++) step(win, 1'b0, 0, 1'b0, curSel, tag);
  endtask

  // Monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        applied++;
        if (pgoodRelease !== it.exp) begin
          bad++;
          $display("FAIL %s: pgoodRelease=%b expected %b", it.tag, pgoodRelease, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < PG_PHASES; p++) cntM[p] = 0;
    threePhase = 1'b0;
    repeat (3) @(negedge clk);
    applied++;
    if (pgoodRelease !== 1'b0) begin
      bad++;
      $display("FAIL R8: pgoodRelease=%b expected 0 in reset", pgoodRelease);
    end
    rstN = 1'b1;
    // R8: still low until first in-window evaluation; select change to three phases
    step(1'b0, 1'b0, 0, 1'b0, 1'b1, "R8 out of window after reset");
    idle(1'b1, 2, "R2 in window good");
    idle(1'b0, 1, "R1 out of window");
    idle(1'b1, 1, "R2 recover");
    // R3/R5: phase 0 misses interleaved with other phases seeing current
    tickp(0, 1'b0, "R5 miss 1");
    tickp(1, 1'b1, "R5 other seen");
    tickp(2, 1'b1, "R5 other seen");
    tickp(0, 1'b0, "R5 miss 2");
    idle(1'b1, 2, "R10 no tick keeps count");
    tickp(1, 1'b1, "R5 other seen");
    tickp(0, 1'b0, "R3 third miss");
    idle(1'b1, 1, "R3 fault drops pgood");
    // R9 saturation
    tickp(0, 1'b0, "R9 extra miss");
    tickp(0, 1'b0, "R9 extra miss");
    idle(1'b1, 1, "R9 still faulted");
    // R1 dominance
    idle(1'b0, 1, "R1 out of window while faulted");
    // R4 recovery
    tickp(0, 1'b1, "R4 current returns");
    idle(1'b1, 2, "R4 pgood back");
    // R6 two-phase mode: phase 2 ignored
    curSel = 1'b0;
    idle(1'b1, 1, "R7 select change");
    for (int i = 0; i < 5; i++) tickp(2, 1'b0, "R6 unselected phase ignored");
    idle(1'b1, 1, "R6 pgood stays");
    // R7 clearing by select change
    tickp(1, 1'b0, "R7 miss 1");
    tickp(1, 1'b0, "R7 miss 2");
    curSel = 1'b1;
    step(1'b1, 1'b1, 1, 1'b0, curSel, "R7 tick in change cycle ignored");
    tickp(1, 1'b0, "R7 miss after clear");
    tickp(1, 1'b0, "R7 miss after clear");
    idle(1'b1, 1, "R7 no fault yet");
    tickp(1, 1'b0, "R3 third miss phase 1");
    idle(1'b1, 2, "R3 faulted phase 1");
    curSel = 1'b0;
    idle(1'b1, 3, "R7 change clears fault");
    // R3 in two-phase mode on phase 0
    for (int i = 0; i < 3; i++) tickp(0, 1'b0, "R3 two-phase misses");
    idle(1'b1, 2, "R3 two-phase fault");
    tickp(0, 1'b1, "R4 two-phase recover");
    idle(1'b1, 2, "R4 two-phase good");
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule